// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog timer with a two-step expiry. Software arms it by setting two enable bits. They sit in two different control words, so one stray write cannot start or stop it. While it is armed, an internal period counter runs through 2^N clock cycles.

The first time the period runs out, the block pulses its interrupt output and sets a state flag. Software is then expected to service it. If a second period runs out with no service, the block drives its reset output for a fixed number of cycles and records the event in a sticky reset-status flag.

Software services the watchdog by writing a one to the state flag. That write clears the flag and restarts the period. A free-running timebase counter can be read at any time, for example to confirm that the block is being clocked. A build option makes the enables sticky once the watchdog runs, so software can no longer stop it.

Top module: `wdt_top`

## Requirements
- R1: After the external reset, both control words read 0, and `irq_o` and `wdt_rst_o` are low.
- R2: The period counter runs only while control word 0 bit 1 and control word 1 bit 0 are both 1. Clearing either bit stops it. While it is stopped the count is held at zero, so re-arming starts a full period.
- R3: When 2^INTERVAL_LOG2 rising edges have passed since the period started (the arming write or the last service write), `irq_o` is high for exactly one cycle and control word 0 bit 2 (the state flag) reads 1.
- R4: Writing 1 to control word 0 bit 2 clears the state flag and restarts the period. A service write that lands on the very edge of an overflow wins, and no overflow is taken.
- R5: If the state flag is still set when the next period ends, `wdt_rst_o` goes high for exactly RST_CYCLES cycles and control word 0 bit 3 (reset status) is set.
- R6: That watchdog reset clears both enables, the state flag and the count, but keeps bit 3. Bit 3 is cleared only by writing 1 to it or by the external reset.
- R7: Offset 0x8 returns a counter that advances by one on every clock. Two reads k cycles apart differ by k, and writes to 0x8 have no effect on it.
- R8: With ENABLE_ONCE set, writes cannot clear either enable while both are set. Before both are set, the enables can still be written freely. With ENABLE_ONCE clear, the enables are always writable.
- R9: Read data appears on `bus_rdata` one cycle after the read strobe. Reads of any offset other than 0x0, 0x4 and 0x8 return 0, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | One-cycle pulse on the first expiry |
| wdt_rst_o | output | 1 | Reset request, held RST_CYCLES cycles on the second expiry |

## Verification
The bench builds the block with INTERVAL_LOG2 = 4 and RST_CYCLES = 3, so one period is only 16 cycles and a full expiry takes 32. This short period lets the bench try every service spacing from 2 up to 16 edges. That range includes the tie where a service write coincides with an overflow. It can also time the interrupt and reset edges against exact cycle counts worked out from the last arming or service write. A second instance, built with ENABLE_ONCE = 1, shares the same bus. The bench compares the two instances to show that the sticky enable blocks clearing writes only after the watchdog is running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DW = 32;
  // byte offsets of the mapped words
  localparam int unsigned OFS_CSR0 = 0;
  localparam int unsigned OFS_CSR1 = 4;
  localparam int unsigned OFS_TB   = 8;
  // bit positions, control word 0
  localparam int unsigned BIT_RSTS  = 3;
  localparam int unsigned BIT_STATE = 2;
  localparam int unsigned BIT_EN1   = 1;
  // bit position, control word 1
  localparam int unsigned BIT_EN2   = 0;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int unsigned TB_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TB_W-1:0] tb_o
);
  logic [TB_W-1:0] tb_q, tb_d;

  always_comb tb_d = tb_q + TB_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_d;
  end

  assign tb_o = tb_q;
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry #(
  parameter int unsigned INTERVAL_LOG2 = 16,
  parameter int unsigned RST_CYCLES    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic kick_i,
  output logic state_o,
  output logic irq_o,
  output logic fire_o,
  output logic wdt_rst_o
);
  localparam int unsigned RCW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [INTERVAL_LOG2-1:0] CNT_LAST = '1;

  logic [INTERVAL_LOG2-1:0] cnt_q, cnt_d;
  logic                     state_q, state_d;
  logic                     irq_q, irq_d;
  logic                     rst_q, rst_d;
  logic [RCW-1:0]           rc_q, rc_d;
  logic                     ovf, fire;

  // a service write on the overflow edge takes priority
  assign ovf  = run_i && !kick_i && (cnt_q == CNT_LAST);
  assign fire = ovf && state_q;

  always_comb begin
    cnt_d   = (!run_i || kick_i) ? '0 : cnt_q + INTERVAL_LOG2'(1);
    irq_d   = ovf && !state_q;
    state_d = state_q;
    if (kick_i)   state_d = 1'b0;
    else if (ovf) state_d = !state_q;   // first sets, second clears with the reset
    rst_d = rst_q;
    rc_d  = rc_q;
    if (fire) begin
      rst_d = 1'b1;
      rc_d  = RCW'(RST_CYCLES - 1);
    end else if (rst_q) begin
      if (rc_q == '0) rst_d = 1'b0;
      else            rc_d  = rc_q - RCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      rc_q    <= '0;
    end else begin
      cnt_q   <= cnt_d;
      state_q <= state_d;
      irq_q   <= irq_d;
      rst_q   <= rst_d;
      rc_q    <= rc_d;
    end
  end

  assign state_o   = state_q;
  assign irq_o     = irq_q;
  assign fire_o    = fire;
  assign wdt_rst_o = rst_q;

  // R3: interrupt is a single-cycle pulse
  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R2: no interrupt can follow a cycle in which the watchdog is not armed
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !irq_q);
  // R5: reset request only rises after the state flag was set
  a_r5_needs_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(state_q));

  generate
    if (RST_CYCLES > 1) begin : g_hold_chk
      // R5: reset request lasts beyond its first cycle
      a_r5_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_q) |=> rst_q);
    end
  endgenerate
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned TB_W        = 32,
  parameter bit          ENABLE_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [TB_W-1:0]   tb_i,
  input  logic              state_i,
  input  logic              fire_i,
  output logic              run_o,
  output logic              kick_o
);
  logic          sel0, sel1, seltb, wr0, wr1, lock;
  logic          en1_q, en1_d, en2_q, en2_d, rsts_q, rsts_d;
  logic [DW-1:0] rdata_q, rd_val;

  assign sel0  = (addr_i == ADDR_W'(OFS_CSR0));
  assign sel1  = (addr_i == ADDR_W'(OFS_CSR1));
  assign seltb = (addr_i == ADDR_W'(OFS_TB));
  assign wr0   = wr_i && sel0;
  assign wr1   = wr_i && sel1;
  assign run_o = en1_q && en2_q;
  assign lock  = ENABLE_ONCE && run_o;
  assign kick_o = wr0 && wdata_i[BIT_STATE];

  always_comb begin
    en1_d  = en1_q;
    en2_d  = en2_q;
    rsts_d = rsts_q;
    if (wr0 && !lock) en1_d = wdata_i[BIT_EN1];
    if (wr1 && !lock) en2_d = wdata_i[BIT_EN2];
    if (wr0 && wdata_i[BIT_RSTS]) rsts_d = 1'b0;
    if (fire_i) begin
      en1_d  = 1'b0;
      en2_d  = 1'b0;
      rsts_d = 1'b1;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel0) begin
      rd_val[BIT_RSTS]  = rsts_q;
      rd_val[BIT_STATE] = state_i;
      rd_val[BIT_EN1]   = en1_q;
    end else if (sel1) begin
      rd_val[BIT_EN2] = en2_q;
    end else if (seltb) begin
      rd_val = DW'(tb_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1_q   <= 1'b0;
      en2_q   <= 1'b0;
      rsts_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      en1_q  <= en1_d;
      en2_q  <= en2_d;
      rsts_q <= rsts_d;
      if (rd_i) rdata_q <= rd_val;
    end
  end

  assign rdata_o = rdata_q;

  // R6: a watchdog reset always leaves the status flag set
  a_r6_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> rsts_q && !run_o);
  // R9: unmapped offsets read back as zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !sel0 && !sel1 && !seltb) |=> (rdata_q == '0));

  generate
    if (ENABLE_ONCE) begin : g_once_chk
      // R8: once running, only a watchdog reset can stop it
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !fire_i) |=> run_o);
    end
  endgenerate
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned TB_W          = 32,
  parameter int unsigned INTERVAL_LOG2 = 16,
  parameter int unsigned RST_CYCLES    = 8,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter bit          ENABLE_ONCE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   srst_n;
  logic [TB_W-1:0]        tb;
  logic                   run, kick, state, fire;

  // reset asserts at once, releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = sync_q[SYNC_STAGES-1];

  wdt_timebase #(.TB_W(TB_W)) u_tb (
    .clk  (clk),
    .rst_n(srst_n),
    .tb_o (tb)
  );

  wdt_regs #(
    .ADDR_W     (ADDR_W),
    .TB_W       (TB_W),
    .ENABLE_ONCE(ENABLE_ONCE)
  ) u_regs (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_i   (bus_wr),
    .rd_i   (bus_rd),
    .addr_i (bus_addr),
    .wdata_i(bus_wdata),
    .rdata_o(bus_rdata),
    .tb_i   (tb),
    .state_i(state),
    .fire_i (fire),
    .run_o  (run),
    .kick_o (kick)
  );

  wdt_expiry #(
    .INTERVAL_LOG2(INTERVAL_LOG2),
    .RST_CYCLES   (RST_CYCLES)
  ) u_exp (
    .clk      (clk),
    .rst_n    (srst_n),
    .run_i    (run),
    .kick_i   (kick),
    .state_o  (state),
    .irq_o    (irq_o),
    .fire_o   (fire),
    .wdt_rst_o(wdt_rst_o)
  );
endmodule

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;
  localparam int N   = 4;
  localparam int PER = 1 << N;
  localparam int RC  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bwr = 1'b0, brd = 1'b0;
  logic [3:0]  baddr = '0;
  logic [31:0] bwd = '0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1, wr0o, wr1o;
  logic [31:0] r0, r1;

  int cyc = 0, checks = 0, errors = 0, wr_cyc = 0;
  int irq0_n = 0, irq0_at = -1, irq1_n = 0, irq1_at = -1;
  int rst0_hi = 0, rst0_at = -1, rst1_hi = 0, rst1_at = -1;
  logic rst0_p = 1'b0, rst1_p = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_top #(.INTERVAL_LOG2(N), .RST_CYCLES(RC), .ENABLE_ONCE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_rd(brd), .bus_addr(baddr),
    .bus_wdata(bwd), .bus_rdata(rd0), .irq_o(irq0), .wdt_rst_o(wr0o));
  wdt_top #(.INTERVAL_LOG2(N), .RST_CYCLES(RC), .ENABLE_ONCE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_rd(brd), .bus_addr(baddr),
    .bus_wdata(bwd), .bus_rdata(rd1), .irq_o(irq1), .wdt_rst_o(wr1o));

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (irq0) begin irq0_n = irq0_n + 1; irq0_at = cyc; end
    if (irq1) begin irq1_n = irq1_n + 1; irq1_at = cyc; end
    if (wr0o && !rst0_p) rst0_at = cyc;
    if (wr1o && !rst1_p) rst1_at = cyc;
    if (wr0o) rst0_hi = rst0_hi + 1;
    if (wr1o) rst1_hi = rst1_hi + 1;
    rst0_p = wr0o;
    rst1_p = wr1o;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog all requirements actual %0d cycles expected under 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bwr = 1'b1; baddr = a; bwd = d;
    @(negedge clk); bwr = 1'b0; wr_cyc = cyc;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); brd = 1'b1; baddr = a;
    @(negedge clk); brd = 1'b0; r0 = rd0; r1 = rd1;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int e, k, n0, h0;
    logic [31:0] ta, tb2, tc;
    do_reset();
    // R1: reset state
    chk("R1", "irq", irq0, 0);
    chk("R1", "wdt_rst", wr0o, 0);
    rd(4'h0); chk("R1", "csr0", r0, 0);
    rd(4'h4); chk("R1", "csr1", r0, 0);

    // R8: enables writable before running, sticky once running
    wr(4'h0, 32'h2); wr(4'h0, 32'h0);
    rd(4'h0); chk("R8", "once csr0 before run", r1, 0);
    wr(4'h4, 32'h1); wr(4'h0, 32'h2); e = wr_cyc;
    n0 = irq0_n; h0 = rst1_hi;
    wr(4'h0, 32'h0); wr(4'h4, 32'h0);
    rd(4'h0); chk("R8", "once csr0 held", r1, 2); chk("R8", "plain csr0 cleared", r0, 0);
    rd(4'h4); chk("R8", "once csr1 held", r1, 1); chk("R8", "plain csr1 cleared", r0, 0);
    wait_until(e + 2*PER + 6);
    chk("R8", "once irq cycle", irq1_at, e + PER);
    chk("R8", "once reset cycle", rst1_at, e + 2*PER);
    chk("R5", "once reset width", rst1_hi - h0, RC);
    chk("R2", "plain stopped no irq", irq0_n - n0, 0);
    rd(4'h0); chk("R6", "once status after fire", r1, 8);
    do_reset();
    rd(4'h0); chk("R6", "status cleared by ext reset", r1, 0);

    // R9: unmapped offsets
    rd(4'hC); chk("R9", "read 0xC", r0, 0);
    rd(4'h1); chk("R9", "read 0x1", r0, 0);
    wr(4'hC, 32'hFFFF_FFFF); wr(4'h6, 32'hFFFF_FFFF);
    rd(4'h0); chk("R9", "csr0 after stray write", r0, 0);
    rd(4'h4); chk("R9", "csr1 after stray write", r0, 0);
    chk("R9", "no irq after stray write", irq0, 0);

    // R7: timebase
    for (int i = 0; i < 4; i++) begin
      rd(4'h8); ta = r0;
      rd(4'h8); tb2 = r0;
      chk("R7", "back-to-back delta", tb2 - ta, 2);
      wr(4'h8, 32'h0);
      rd(4'h8); tc = r0;
      chk("R7", "delta across write", tc - tb2, 4);
    end

    // R2: both enables required, stop resets the period
    n0 = irq0_n;
    wr(4'h0, 32'h2); wait_until(cyc + 40);
    chk("R2", "en1 only no irq", irq0_n - n0, 0);
    rd(4'h0); chk("R2", "en1 readback", r0, 2);
    wr(4'h4, 32'h1); repeat (5) @(negedge clk); wr(4'h4, 32'h0);
    wait_until(cyc + 40);
    chk("R2", "stopped no irq", irq0_n - n0, 0);
    wr(4'h4, 32'h1); e = wr_cyc;
    wait_until(e + PER + 2);
    chk("R2", "rearm full period", irq0_at, e + PER);
    h0 = rst0_hi;
    wr(4'h0, 32'h0); wait_until(cyc + 40);
    chk("R2", "disarmed no reset", rst0_hi - h0, 0);
    rd(4'h0); chk("R3", "state kept while disarmed", r0, 4);
    wr(4'h0, 32'h4);
    rd(4'h0); chk("R4", "state cleared", r0, 0);

    // R4: service sweep, spacing 2..16 edges (16 = tie with overflow)
    n0 = irq0_n;
    wr(4'h4, 32'h1); wr(4'h0, 32'h2);
    for (int d = 0; d <= 14; d++) begin
      repeat (d) @(negedge clk);
      wr(4'h0, 32'h6);
    end
    k = wr_cyc;
    chk("R4", "no irq during sweep", irq0_n - n0, 0);
    wait_until(k + PER + 4);
    chk("R3", "irq after last service", irq0_at, k + PER);
    chk("R3", "single irq pulse", irq0_n - n0, 1);
    rd(4'h0); chk("R3", "state flag set", r0, 6);
    h0 = rst0_hi;
    wr(4'h0, 32'h6); k = wr_cyc;
    wait_until(k + PER + 2);
    chk("R4", "service after irq restarts", irq0_at, k + PER);
    chk("R4", "service avoided reset", rst0_hi - h0, 0);
    wait_until(k + 2*PER + 8);
    chk("R5", "reset rise cycle", rst0_at, k + 2*PER);
    chk("R5", "reset width", rst0_hi - h0, RC);
    chk("R5", "irq count", irq0_n - n0, 2);
    rd(4'h0); chk("R6", "csr0 after fire", r0, 8);
    rd(4'h4); chk("R6", "csr1 after fire", r0, 0);
    wait_until(cyc + 40);
    chk("R6", "no further irq", irq0_n - n0, 2);
    wr(4'h0, 32'h8);
    rd(4'h0); chk("R6", "status write-one clear", r0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule